// File: doc/BRIEF.md
# Parity-Error NACK Stop-Bit Generator

This block sits beside a UART receiver and answers a character that arrived with bad parity by pulling the serial line low during that character's stop interval. The receiver on the far side sees the low level where it expects a stop bit and can retry the character. The scheme follows smartcard-style error signalling. The block does not deserialise anything itself. It works from three things: a tick at sixteen times the baud rate, a strobe from the receiver that marks the first tick of the stop interval, and the receiver's parity verdict for the character that has just ended.

Signalling is allowed only in one frame format: eight data bits followed by two stop bits, with the feature switched on. Every other combination leaves the line released. The two-bit stop interval lasts 32 ticks. The drive window skips the first 8 ticks and covers the last 24, which is one and a half bit times. The output pair is a drive enable and a drive level. A parameter selects whether that pair is registered, which adds one clock of latency.

Top module: `nack_stop_gen`

## Requirements
- R1: While reset is held and right after it is released, `line_oe` is 0 and `line_lvl` is 1.
- R2: A window is armed only if, in the `stop_begin` cycle, all four of these hold: `cfg_nack_en` is 1, `cfg_len` is 2'b11, `cfg_stop_two` is 1 and `parity_bad` is 1. The `cfg_len` codes 2'b00, 2'b01, 2'b10 and 2'b11 mean 5, 6, 7 and 8 data bits. In every other case the line stays released.
- R3: The tick that comes with `stop_begin` is tick 0. For an armed window, the drive is on while the number of later ticks counted is between 8 and 31 inclusive. It switches off at the 32nd tick. With `OUT_REG`=1 the outputs lag this count by one clock.
- R4: While the window is active, `line_oe` is 1 and `line_lvl` is 0. At all other times `line_oe` is 0 and `line_lvl` is 1.
- R5: Changes to the configuration inputs or to `parity_bad` after the `stop_begin` cycle have no effect on a window that has already been armed or rejected.
- R6: A new `stop_begin` always restarts the tick count and qualifies the frame again. An active window is cut short if the new frame does not qualify, and starts over at tick 8 if it does.
- R7: `line_oe` changes value only in the cycle that follows a tick or a `stop_begin` by the output latency. That latency is one clock, or two clocks when `OUT_REG`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_x16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| stop_begin | input | 1 | Marks the first tick of a character's stop interval; asserted together with a tick |
| parity_bad | input | 1 | Parity verdict for the character; read only when `stop_begin` is high |
| cfg_nack_en | input | 1 | Enables error signalling; 0 after reset |
| cfg_len | input | 2 | Data-length code: 2'b00 to 2'b11 mean 5 to 8 bits |
| cfg_stop_two | input | 1 | 1 selects two stop bits |
| line_oe | output | 1 | Drive enable for the serial line |
| line_lvl | output | 1 | Level driven onto the line: 0 inside the window, 1 otherwise |

## Verification
The checker relies on two assumptions about the inputs. First, `stop_begin` is only ever asserted in a cycle that also carries a tick. Second, ticks are single-cycle pulses, so the number of ticks seen while the line is driven stays within the 24-tick window. The bench produces every tick from one fixed period per run and always raises `stop_begin` on a tick cycle. It sweeps every combination of enable, length code, stop count and parity verdict at tick periods of one and three clocks, and then runs frames where the configuration is scrambled after the start strobe and frames that are restarted part way through the window.

// File: rtl/nack_pkg.sv
package nack_pkg;

   typedef enum logic [1:0] {
      LEN_5 = 2'b00,
      LEN_6 = 2'b01,
      LEN_7 = 2'b10,
      LEN_8 = 2'b11
   } data_len_e;

   typedef struct packed {
      logic      en;
      data_len_e len;
      logic      stop_two;
      logic      perr;
   } frame_cfg_t;

endpackage

// File: rtl/nack_qualify.sv
module nack_qualify
   import nack_pkg::*;
#(
   parameter data_len_e REQ_LEN  = LEN_8,
   parameter bit        REQ_STOP = 1'b1
) (
   input  frame_cfg_t cfg,
   output logic       arm
);

   always_comb begin
      arm = cfg.en && cfg.perr &&
            (cfg.len == REQ_LEN) && (cfg.stop_two == REQ_STOP);
   end

endmodule

// File: rtl/nack_window_timer.sv
module nack_window_timer #(
   parameter int LEAD_TICKS = 8,
   parameter int WIN_TICKS  = 24,
   localparam int END_TICK  = LEAD_TICKS + WIN_TICKS,
   localparam int CW        = $clog2(END_TICK + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic arm,
   output logic window
);

   logic          active_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= arm;
         cnt_q    <= '0;
      end else if (active_q && tick) begin
         if (cnt_q == CW'(END_TICK - 1)) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      window = active_q && (cnt_q >= CW'(LEAD_TICKS));
   end

endmodule

// File: rtl/nack_line_driver.sv
module nack_line_driver #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic window,
   output logic oe,
   output logic lvl
);

   logic drv;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drv <= 1'b0;
            else        drv <= window;
         end
      end else begin : g_comb
         always_comb drv = window;
      end
   endgenerate

   always_comb begin
      oe  = drv;
      lvl = !drv;
   end

endmodule

// File: rtl/nack_stop_gen.sv
module nack_stop_gen
   import nack_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int STOP_BITS  = 2,
   parameter int LEAD_TICKS = OVERSAMPLE / 2,
   parameter bit OUT_REG    = 1'b1,
   localparam int WIN_TICKS = STOP_BITS * OVERSAMPLE - LEAD_TICKS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_x16,
   input  logic       stop_begin,
   input  logic       parity_bad,
   input  logic       cfg_nack_en,
   input  logic [1:0] cfg_len,
   input  logic       cfg_stop_two,
   output logic       line_oe,
   output logic       line_lvl
);

   generate
      if (OVERSAMPLE < 4) begin : g_bad_os
         $error("OVERSAMPLE must be at least 4");
      end
      if (LEAD_TICKS < 1 || WIN_TICKS < 1) begin : g_bad_win
         $error("window must have a lead and a length of at least one tick");
      end
   endgenerate

   frame_cfg_t cfg;
   logic       arm;
   logic       window;

   always_comb begin
      cfg.en       = cfg_nack_en;
      cfg.len      = data_len_e'(cfg_len);
      cfg.stop_two = cfg_stop_two;
      cfg.perr     = parity_bad;
   end

   nack_qualify #(
      .REQ_LEN  (LEN_8),
      .REQ_STOP (1'b1)
   ) u_qual (
      .cfg (cfg),
      .arm (arm)
   );

   nack_window_timer #(
      .LEAD_TICKS (LEAD_TICKS),
      .WIN_TICKS  (WIN_TICKS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_x16),
      .start  (stop_begin),
      .arm    (arm),
      .window (window)
   );

   nack_line_driver #(
      .OUT_REG (OUT_REG)
   ) u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .window (window),
      .oe     (line_oe),
      .lvl    (line_lvl)
   );

endmodule

// File: rtl/nack_stop_gen_chk.sv
module nack_stop_gen_chk #(
   parameter int OVERSAMPLE = 16,
   parameter int STOP_BITS  = 2,
   parameter int LEAD_TICKS = 8,
   parameter bit OUT_REG    = 1'b1,
   localparam int WIN_TICKS = STOP_BITS * OVERSAMPLE - LEAD_TICKS,
   localparam int LAT       = OUT_REG ? 2 : 1,
   localparam int RW        = $clog2(WIN_TICKS + 2)
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_x16,
   input logic       stop_begin,
   input logic       parity_bad,
   input logic       cfg_nack_en,
   input logic [1:0] cfg_len,
   input logic       cfg_stop_two,
   input logic       line_oe,
   input logic       line_lvl
);

   logic          qual_seen, qual_seen_d, qual_ref;
   logic [RW-1:0] run_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_seen   <= 1'b0;
         qual_seen_d <= 1'b0;
         run_ticks   <= '0;
      end else begin
         if (stop_begin)
            qual_seen <= cfg_nack_en && parity_bad && cfg_stop_two && (cfg_len == 2'b11);
         qual_seen_d <= qual_seen;
         if (!line_oe)      run_ticks <= '0;
         else if (tick_x16) run_ticks <= run_ticks + 1'b1;
      end
   end

   always_comb qual_ref = OUT_REG ? qual_seen_d : qual_seen;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (!line_oe && line_lvl));

   assert_only_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> qual_ref);

   assert_quiet_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_begin |=> ##1 !line_oe);

   assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe && tick_x16) |-> (run_ticks < RW'(WIN_TICKS)));

   assert_level_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> !line_lvl);

   assert_change_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_oe) |-> $past(tick_x16 || stop_begin, LAT));

endmodule

bind nack_stop_gen nack_stop_gen_chk #(
   .OVERSAMPLE (OVERSAMPLE),
   .STOP_BITS  (STOP_BITS),
   .LEAD_TICKS (LEAD_TICKS),
   .OUT_REG    (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_x16     (tick_x16),
   .stop_begin   (stop_begin),
   .parity_bad   (parity_bad),
   .cfg_nack_en  (cfg_nack_en),
   .cfg_len      (cfg_len),
   .cfg_stop_two (cfg_stop_two),
   .line_oe      (line_oe),
   .line_lvl     (line_lvl)
);

// File: tb/nack_stop_gen_tb.sv
module nack_stop_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_x16 = 1'b0;
   logic       stop_begin = 1'b0;
   logic       parity_bad = 1'b0;
   logic       cfg_nack_en = 1'b0;
   logic [1:0] cfg_len = 2'b00;
   logic       cfg_stop_two = 1'b0;
   logic       line_oe, line_lvl;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = !clk;

   nack_stop_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_x16     (tick_x16),
      .stop_begin   (stop_begin),
      .parity_bad   (parity_bad),
      .cfg_nack_en  (cfg_nack_en),
      .cfg_len      (cfg_len),
      .cfg_stop_two (cfg_stop_two),
      .line_oe      (line_oe),
      .line_lvl     (line_lvl)
   );

   task automatic check_out(input bit exp_drv, input string req);
      vectors++;
      if (line_oe !== exp_drv || line_lvl !== !exp_drv) begin
         fails++;
         $display("FAIL %s: oe=%b lvl=%b expected oe=%b lvl=%b at %0t",
                  req, line_oe, line_lvl, exp_drv, !exp_drv, $time);
      end
   endtask

   // mode 0: plain frame; mode 1: scramble config after start (R5);
   // mode 2: restart at cycle rcyc with second config (R6)
   task automatic run_frame(input bit en, input bit [1:0] len, input bit s2,
                            input bit pe, input int per, input int mode,
                            input int rcyc, input bit [3:0] cfg2);
      bit qa = 1'b0;
      int k = 0;
      bit comb_prev = 1'b0;
      int ncyc = (mode == 2) ? (rcyc + 34 * per + 4) : (34 * per + 4);
      bit q_any = 1'b0;
      string tag;
      for (int c = 0; c < ncyc; c++) begin
         bit st, tk, q, comb_now;
         st = (c == 0) || (mode == 2 && c == rcyc);
         tk = st || (c % per == 0);
         @(negedge clk);
         if (c == 0) begin
            cfg_nack_en = en; cfg_len = len; cfg_stop_two = s2; parity_bad = pe;
         end else if (mode == 2 && c == rcyc) begin
            {cfg_nack_en, cfg_len, cfg_stop_two, parity_bad} = {cfg2[3], 2'b11, cfg2[1], cfg2[0]};
            if (!cfg2[2]) cfg_len = 2'b10;
         end else if (mode == 1) begin
            cfg_nack_en = !en; cfg_len = ~len; cfg_stop_two = !s2; parity_bad = !pe;
         end
         stop_begin = st;
         tick_x16 = tk;
         q = cfg_nack_en && parity_bad && cfg_stop_two && (cfg_len == 2'b11);
         if (st) begin
            qa = q; k = 0;
         end else if (tk && qa) begin
            k++;
            if (k == 32) begin qa = 1'b0; k = 0; end
         end
         comb_now = qa && (k >= 8);
         q_any = q_any | qa;
         @(posedge clk);
         #1;
         if (mode == 0) tag = q_any ? "R3 R4 R7" : "R2";
         else if (mode == 1) tag = "R5";
         else tag = "R6";
         check_out(comb_prev, tag);
         comb_prev = comb_now;
      end
      @(negedge clk);
      stop_begin = 1'b0;
      tick_x16 = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_out(1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_out(1'b0, "R1");

      // R2 R3 R4: sweep every format, enable and parity combination at two tick rates
      for (int per = 1; per <= 3; per += 2)
         for (int v = 0; v < 32; v++)
            run_frame(v[4], v[3:2], v[1], v[0], per, 0, 0, 4'h0);

      // R5: inputs flipped after the start strobe, both a qualified and a rejected frame
      run_frame(1'b1, 2'b11, 1'b1, 1'b1, 1, 1, 0, 4'h0);
      run_frame(1'b1, 2'b11, 1'b1, 1'b1, 3, 1, 0, 4'h0);
      run_frame(1'b0, 2'b00, 1'b0, 1'b0, 2, 1, 0, 4'h0);

      // R6: restart in mid window with a rejected, then a qualified frame
      run_frame(1'b1, 2'b11, 1'b1, 1'b1, 1, 2, 14, 4'b0110);
      run_frame(1'b1, 2'b11, 1'b1, 1'b1, 1, 2, 14, 4'b1111);
      run_frame(1'b1, 2'b11, 1'b1, 1'b1, 3, 2, 45, 4'b1111);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule